// File: doc/BRIEF.md
# Trace Buffer Pointer and Status Controller

This block keeps the write and read pointers of a single-ported trace memory that sits beside it. Each captured event, a 67-bit payload, goes to the memory as a 69-bit entry. The two extra bits carry a valid flag and a gap flag. The gap flag marks an entry as the first one stored after events were lost. A CPU drains the buffer one entry at a time, in two beats. The low beat fetches the entry from memory and returns bits 63:0. The high beat returns bits 68:64 and retires the entry.

Capture runs in one of two modes. In wrap mode it keeps going for as long as the reader keeps up, and events that arrive while the buffer is full are dropped. In fill-once mode it stops for good after one buffer's worth of entries. A threshold interrupt reports when the distance from the read pointer to the write pointer climbs to a selected fraction of the depth. A rising edge on the enable starts a new trace from entry 0.

Top module: `tbc_trace_ctrl`

## Requirements
- R1: After reset, `rd_valid`, `thr_irq` and `mem_en` are 0. In the cycle where `trace_en` rises, both pointers return to entry 0, and a capture strobe in that cycle causes no memory write.
- R2: A capture strobe accepted while enabled writes `{gap, 1'b1, cap_data}` (bit 68 gap, bit 67 valid, bits 66:0 payload) at the write pointer in that same cycle (`mem_en`=1, `mem_we`=1). The write pointer then moves to the next entry.
- R3: In wrap mode, with DEPTH unread entries held, a capture strobe is dropped and `mem_we` stays 0. Capture resumes as soon as a read frees an entry.
- R4: The first entry written after one or more dropped captures has bits 68:67 equal to 3. Later entries carry 1 there until the next drop.
- R5: In fill-once mode (`wrap_mode`=0), once DEPTH entries have been written since the enable, further strobes write nothing, even after reads free space. Those strobes set no gap flag.
- R6: A low-beat read request is queued. When it is issued to memory, `rd_valid` pulses 2 cycles later with entry bits 63:0. The read appears 3 cycles after the request when the port is free.
- R7: A high-beat request pulses `rd_valid` one cycle later, with entry bits 68:64 in `rd_data[4:0]` and zeros above. Only this beat advances the read pointer. The low beat alone leaves it unchanged.
- R8: A low beat issued while the buffer is empty touches no memory and returns 0. The following high beat returns status 0, or status 2 if a capture has been dropped since the last stored entry. The read pointer does not move.
- R9: `thr_sel` 1, 2, 3 set the threshold to DEPTH/2, 3·DEPTH/4 and DEPTH; 0 disables it. `thr_irq` pulses for one cycle after each edge at which the occupancy rises to the threshold.
- R10: When a capture write and a queued read issue fall in the same cycle, the write takes the memory port. The read is issued on the next free cycle and returns the entry at the read pointer one cycle later than usual.
- R11: While `trace_en` is 0, capture strobes write nothing and leave the pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en | input | 1 | Capture enable; a rising edge starts a new trace |
| wrap_mode | input | 1 | 1 = keep capturing (wrap), 0 = stop after one fill |
| thr_sel | input | 2 | Threshold select: 0 off, 1 half, 2 three quarters, 3 full |
| cap_valid | input | 1 | Capture strobe |
| cap_data | input | PAYLOAD_W (67) | Event payload |
| rd_lo_req | input | 1 | CPU request for entry bits 63:0 |
| rd_hi_req | input | 1 | CPU request for entry bits 68:64; retires the entry |
| mem_rdata | input | PAYLOAD_W+2 (69) | Memory read data, one cycle after a read access |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write select |
| mem_addr | output | log2(DEPTH) (6) | Memory address |
| mem_wdata | output | PAYLOAD_W+2 (69) | Entry to be written |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| rd_data | output | CPU_W (64) | CPU read data |
| thr_irq | output | 1 | Threshold interrupt pulse |

## Verification
The capture write and the fetch of a queued low-beat read both want the single memory port, and they can land in the same cycle. The bench provokes this by raising a capture strobe in exactly the cycle after a low-beat request, which is when the fetch would otherwise issue. It judges the outcome in three ways: `mem_we` must be high in that cycle, the low beat must arrive one cycle later than on a free port, and the data returned must be the older entry at the read pointer, not the one just written. The other collision, a write and a retiring read in one cycle, is covered by the threshold rule. There the occupancy does not change, so no interrupt may fire.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

  typedef enum logic [1:0] {
    ST_NONE      = 2'd0,
    ST_DATA      = 2'd1,
    ST_NONE_GAP  = 2'd2,
    ST_DATA_GAP  = 2'd3
  } tbc_status_e;

  // Two status bits kept above the payload: bit 1 = gap, bit 0 = valid.
  function automatic logic [1:0] tbc_status(input logic valid, input logic gap);
    return {gap, valid};
  endfunction

  // Occupancy level at which the threshold interrupt fires; 0 = disabled.
  function automatic int unsigned tbc_thr_level(input logic [1:0] sel,
                                                input int unsigned depth);
    case (sel)
      2'd1:    return depth / 2;
      2'd2:    return depth - depth / 4;
      2'd3:    return depth;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tbc_wr_ctl.sv
module tbc_wr_ctl
  import tbc_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int PAYLOAD_W = 67,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1,
  localparam int ENTRY_W  = PAYLOAD_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 trace_en,
  input  logic                 wrap_mode,
  input  logic                 cap_valid,
  input  logic [PAYLOAD_W-1:0] cap_data,
  input  logic [PW-1:0]        rd_ptr,
  output logic                 wr_fire,
  output logic                 drop_evt,
  output logic                 gap_pend,
  output logic [PW-1:0]        wr_ptr,
  output logic [ENTRY_W-1:0]   wr_entry
);

  function automatic logic [PW-1:0] occupancy(input logic [PW-1:0] w,
                                              input logic [PW-1:0] r);
    return w - r;
  endfunction

  logic filled_q;
  logic is_full, is_halted, cap_ok;

  assign is_full   = (occupancy(wr_ptr, rd_ptr) == PW'(DEPTH));
  assign is_halted = !wrap_mode && filled_q;
  assign cap_ok    = trace_en && !start && cap_valid;
  assign wr_fire   = cap_ok && !is_full && !is_halted;
  assign drop_evt  = cap_ok && is_full && !is_halted;
  assign wr_entry  = {tbc_status(1'b1, gap_pend), cap_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      filled_q <= 1'b0;
      gap_pend <= 1'b0;
    end else if (start) begin
      wr_ptr   <= '0;
      filled_q <= 1'b0;
      gap_pend <= 1'b0;
    end else if (wr_fire) begin
      wr_ptr   <= wr_ptr + PW'(1);
      gap_pend <= 1'b0;
      if (&wr_ptr[AW-1:0]) filled_q <= 1'b1;
    end else if (drop_evt) begin
      gap_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/tbc_rd_ctl.sv
module tbc_rd_ctl
  import tbc_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int PAYLOAD_W = 67,
  parameter int CPU_W     = 64,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1,
  localparam int ENTRY_W  = PAYLOAD_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               rd_lo_req,
  input  logic               rd_hi_req,
  input  logic               wr_busy,
  input  logic [PW-1:0]      wr_ptr,
  input  logic               gap_pend,
  input  logic [ENTRY_W-1:0] mem_rdata,
  output logic               mem_re,
  output logic [PW-1:0]      rd_ptr,
  output logic               rd_adv,
  output logic               rd_valid,
  output logic [CPU_W-1:0]   rd_data
);

  logic               lo_pend_q, fetch_q, fetch_empty_q, hold_ok_q;
  logic [ENTRY_W-1:0] hold_q, fetch_word;
  logic               issue, buf_empty;

  assign buf_empty  = (wr_ptr == rd_ptr);
  assign issue      = lo_pend_q && !wr_busy;
  assign mem_re     = issue && !buf_empty;
  assign rd_adv     = rd_hi_req && hold_ok_q && !fetch_q;
  assign fetch_word = fetch_empty_q ? {tbc_status(1'b0, gap_pend), {PAYLOAD_W{1'b0}}}
                                    : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_pend_q     <= 1'b0;
      fetch_q       <= 1'b0;
      fetch_empty_q <= 1'b0;
      hold_ok_q     <= 1'b0;
      hold_q        <= '0;
      rd_ptr        <= '0;
      rd_valid      <= 1'b0;
      rd_data       <= '0;
    end else if (start) begin
      lo_pend_q     <= 1'b0;
      fetch_q       <= 1'b0;
      fetch_empty_q <= 1'b0;
      hold_ok_q     <= 1'b0;
      rd_ptr        <= '0;
      rd_valid      <= 1'b0;
    end else begin
      rd_valid      <= 1'b0;
      fetch_q       <= issue;
      fetch_empty_q <= buf_empty;
      if (issue)     lo_pend_q <= 1'b0;
      if (rd_lo_req) lo_pend_q <= 1'b1;
      if (fetch_q) begin
        hold_q    <= fetch_word;
        hold_ok_q <= !fetch_empty_q;
        rd_valid  <= 1'b1;
        rd_data   <= fetch_word[CPU_W-1:0];
      end else if (rd_hi_req) begin
        rd_valid <= 1'b1;
        rd_data  <= CPU_W'(hold_q[ENTRY_W-1:CPU_W]);
        if (hold_ok_q) begin
          rd_ptr    <= rd_ptr + PW'(1);
          hold_ok_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/tbc_thr.sv
module tbc_thr
  import tbc_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int LW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    thr_sel,
  input  logic          wr_fire,
  input  logic          rd_adv,
  input  logic [PW-1:0] wr_ptr,
  input  logic [PW-1:0] rd_ptr,
  output logic          thr_irq
);

  function automatic logic [LW-1:0] next_level(input logic [LW-1:0] cur,
                                               input logic inc, input logic dec);
    return cur + LW'(inc) - LW'(dec);
  endfunction

  logic [LW-1:0] cur_lvl, nxt_lvl, goal;
  logic          crossing;

  assign cur_lvl  = {1'b0, PW'(wr_ptr - rd_ptr)};
  assign nxt_lvl  = next_level(cur_lvl, wr_fire, rd_adv);
  assign goal     = LW'(tbc_thr_level(thr_sel, DEPTH));
  assign crossing = (thr_sel != 2'd0) && (cur_lvl < goal) && (nxt_lvl >= goal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     thr_irq <= 1'b0;
    else if (start) thr_irq <= 1'b0;
    else            thr_irq <= crossing;
  end

endmodule

// File: rtl/tbc_trace_ctrl.sv
module tbc_trace_ctrl
  import tbc_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int PAYLOAD_W = 67,
  parameter int CPU_W     = 64,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1,
  localparam int ENTRY_W  = PAYLOAD_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trace_en,
  input  logic                 wrap_mode,
  input  logic [1:0]           thr_sel,
  input  logic                 cap_valid,
  input  logic [PAYLOAD_W-1:0] cap_data,
  input  logic                 rd_lo_req,
  input  logic                 rd_hi_req,
  input  logic [ENTRY_W-1:0]   mem_rdata,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [ENTRY_W-1:0]   mem_wdata,
  output logic                 rd_valid,
  output logic [CPU_W-1:0]     rd_data,
  output logic                 thr_irq
);

  logic          en_q, start;
  logic          wr_fire, drop_evt, gap_pend, rd_mem_re, rd_adv;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [ENTRY_W-1:0] wr_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= trace_en;
  end
  assign start = trace_en && !en_q;

  tbc_wr_ctl #(.DEPTH(DEPTH), .PAYLOAD_W(PAYLOAD_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .start(start), .trace_en(trace_en),
    .wrap_mode(wrap_mode), .cap_valid(cap_valid), .cap_data(cap_data),
    .rd_ptr(rd_ptr), .wr_fire(wr_fire), .drop_evt(drop_evt),
    .gap_pend(gap_pend), .wr_ptr(wr_ptr), .wr_entry(wr_entry)
  );

  tbc_rd_ctl #(.DEPTH(DEPTH), .PAYLOAD_W(PAYLOAD_W), .CPU_W(CPU_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_lo_req(rd_lo_req),
    .rd_hi_req(rd_hi_req), .wr_busy(wr_fire), .wr_ptr(wr_ptr),
    .gap_pend(gap_pend), .mem_rdata(mem_rdata), .mem_re(rd_mem_re),
    .rd_ptr(rd_ptr), .rd_adv(rd_adv), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  tbc_thr #(.DEPTH(DEPTH)) u_thr (
    .clk(clk), .rst_n(rst_n), .start(start), .thr_sel(thr_sel),
    .wr_fire(wr_fire), .rd_adv(rd_adv), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .thr_irq(thr_irq)
  );

  // Single port: a capture write always owns it; the read waits.
  assign mem_we    = wr_fire;
  assign mem_en    = wr_fire || rd_mem_re;
  assign mem_addr  = wr_fire ? wr_ptr[AW-1:0] : rd_ptr[AW-1:0];
  assign mem_wdata = wr_entry;

endmodule

// File: rtl/tbc_trace_ctrl_chk.sv
module tbc_trace_ctrl_chk #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          wr_fire,
  input logic          drop_evt,
  input logic          rd_mem_re,
  input logic          mem_we,
  input logic          rd_hi_req,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [1:0]    thr_sel,
  input logic          thr_irq
);

  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (wr_ptr == '0 && rd_ptr == '0));

  a_r2_write_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !start) |=> (wr_ptr == $past(wr_ptr) + PW'(1)));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(wr_ptr - rd_ptr) <= PW'(DEPTH));

  a_r3_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> !mem_we);

  a_r7_only_hi_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !rd_hi_req) |=> $stable(rd_ptr));

  a_r8_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi_req && !start && wr_ptr == rd_ptr) |=> (rd_ptr == $past(rd_ptr)));

  a_r9_irq_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    thr_irq |-> ($past(thr_sel) != 2'd0));

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !rd_mem_re);

endmodule

bind tbc_trace_ctrl tbc_trace_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_fire(wr_fire),
  .drop_evt(drop_evt), .rd_mem_re(rd_mem_re), .mem_we(mem_we),
  .rd_hi_req(rd_hi_req), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .thr_sel(thr_sel), .thr_irq(thr_irq)
);

// File: tb/tbc_trace_ctrl_tb_top.sv
`timescale 1ns/1ps
module tbc_trace_ctrl_tb_top;

  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int EW    = 69;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trace_en = 1'b0, wrap_mode = 1'b1;
  logic [1:0]    thr_sel = 2'd0;
  logic          cap_valid = 1'b0;
  logic [66:0]   cap_data = '0;
  logic          rd_lo_req = 1'b0, rd_hi_req = 1'b0;
  logic [EW-1:0] mem_rdata;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [EW-1:0] mem_wdata;
  logic          rd_valid;
  logic [63:0]   rd_data;
  logic          thr_irq;

  logic [EW-1:0] mem_q [DEPTH];

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tbc_trace_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .wrap_mode(wrap_mode),
    .thr_sel(thr_sel), .cap_valid(cap_valid), .cap_data(cap_data),
    .rd_lo_req(rd_lo_req), .rd_hi_req(rd_hi_req), .mem_rdata(mem_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .thr_irq(thr_irq)
  );

  // Single-ported memory model with registered read data.
  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem_q[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem_q[mem_addr];
    end
  end

  localparam logic [66:0] PAT [8] = '{
    67'h1_0000_0000_0000_0001, 67'h7_FFFF_FFFF_FFFF_FFFF,
    67'h0_0000_0000_0000_0000, 67'h2_DEAD_BEEF_0BAD_F00D,
    67'h4_8000_0000_0000_0000, 67'h3_1234_5678_9ABC_DEF0,
    67'h5_5555_5555_5555_5555, 67'h6_AAAA_AAAA_AAAA_AAAA
  };

  function automatic logic [66:0] pl(input int i);
    return {3'(i), 32'hA5A5_0000 | 32'(i), 32'(i * 7 + 3)};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [EW-1:0] act, input logic [EW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Drive one capture strobe; check whether it reaches the memory.
  task automatic cap(input logic [66:0] d, input bit exp_wr, input string req);
    cap_valid = 1'b1;
    cap_data  = d;
    #1;
    chk((mem_en && mem_we) == exp_wr, req, EW'(mem_en && mem_we), EW'(exp_wr));
    @(posedge clk);
    #1;
    cap_valid = 1'b0;
  endtask

  task automatic rd_entry(output logic [EW-1:0] e, output int lat, output bit hi_ok);
    rd_lo_req = 1'b1;
    step();
    rd_lo_req = 1'b0;
    lat = 1;
    while (!rd_valid && lat < 20) begin
      step();
      lat++;
    end
    e[63:0] = rd_data;
    rd_hi_req = 1'b1;
    step();
    rd_hi_req = 1'b0;
    e[68:64] = rd_data[4:0];
    hi_ok = rd_valid && (rd_data[63:5] == '0);
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [EW-1:0] e;
    int lat;
    bit hok;

    // Reset state (R1)
    step(); step();
    chk(!rd_valid && !thr_irq && !mem_en, "R1 reset outputs",
        EW'({rd_valid, thr_irq, mem_en}), '0);
    rst_n = 1'b1;
    step();

    // Enable edge ignores capture in the same cycle (R1)
    trace_en = 1'b1;
    cap_valid = 1'b1;
    cap_data = 67'h7_0000_0000_0000_0BAD;
    #1;
    chk(!mem_en, "R1 capture on enable edge", EW'(mem_en), '0);
    step();
    cap_valid = 1'b0;

    // Vector table: capture, then read back in order (R2, R6, R7)
    for (int i = 0; i < 8; i++) cap(PAT[i], 1'b1, "R2 capture write");
    for (int i = 0; i < 8; i++) begin
      rd_entry(e, lat, hok);
      chk(e === {2'b01, PAT[i]}, "R2 R7 entry content", e, {2'b01, PAT[i]});
      chk(lat == 3, "R6 low beat latency", EW'(lat), EW'(3));
      chk(hok, "R7 high beat shape", EW'(hok), EW'(1));
    end

    // Underflow: zero data, pointer held (R8)
    rd_entry(e, lat, hok);
    chk(e === '0, "R8 underflow read", e, '0);
    cap(pl(50), 1'b1, "R2 capture after underflow");
    rd_entry(e, lat, hok);
    chk(e === {2'b01, pl(50)}, "R8 read pointer held", e, {2'b01, pl(50)});

    // Disabled capture ignored (R11)
    trace_en = 1'b0;
    step();
    cap(pl(51), 1'b0, "R11 capture while disabled");
    rd_entry(e, lat, hok);
    chk(e === '0, "R11 nothing stored", e, '0);

    // New trace: threshold, overflow, discontinuity (R9, R3, R4)
    thr_sel = 2'd1;
    trace_en = 1'b1;
    step();
    for (int i = 0; i < DEPTH; i++) begin
      cap(pl(100 + i), 1'b1, "R3 fill in wrap mode");
      chk(thr_irq == (i == 31 || i == 63), "R9 threshold pulse",
          EW'(thr_irq), EW'(i == 31 || i == 63));
      if (i == 31) thr_sel = 2'd3;
    end
    for (int i = 0; i < 3; i++) begin
      cap(pl(900 + i), 1'b0, "R3 drop while full");
      chk(!thr_irq, "R9 no pulse on drop", EW'(thr_irq), '0);
    end
    for (int i = 0; i < DEPTH; i++) begin
      rd_entry(e, lat, hok);
      chk(e === {2'b01, pl(100 + i)}, "R3 drain after overflow", e, {2'b01, pl(100 + i)});
    end
    rd_entry(e, lat, hok);
    chk(e === {2'b10, 67'b0}, "R8 underflow with gap", e, {2'b10, 67'b0});
    cap(pl(300), 1'b1, "R3 capture resumes");
    cap(pl(301), 1'b1, "R3 capture resumes");
    rd_entry(e, lat, hok);
    chk(e === {2'b11, pl(300)}, "R4 first entry after gap", e, {2'b11, pl(300)});
    rd_entry(e, lat, hok);
    chk(e === {2'b01, pl(301)}, "R4 following entry", e, {2'b01, pl(301)});

    // Write and read fetch in one cycle (R10)
    thr_sel = 2'd0;
    cap(pl(400), 1'b1, "R10 setup");
    rd_lo_req = 1'b1;
    step();
    rd_lo_req = 1'b0;
    cap_valid = 1'b1;
    cap_data = pl(401);
    #1;
    chk(mem_en && mem_we, "R10 write takes port", EW'(mem_we), EW'(1));
    @(posedge clk);
    #1;
    cap_valid = 1'b0;
    lat = 2;
    while (!rd_valid && lat < 20) begin
      step();
      lat++;
    end
    chk(lat == 4, "R10 delayed read latency", EW'(lat), EW'(4));
    e[63:0] = rd_data;
    rd_hi_req = 1'b1;
    step();
    rd_hi_req = 1'b0;
    e[68:64] = rd_data[4:0];
    chk(e === {2'b01, pl(400)}, "R10 older entry returned", e, {2'b01, pl(400)});
    rd_entry(e, lat, hok);
    chk(e === {2'b01, pl(401)}, "R10 contended write stored", e, {2'b01, pl(401)});

    // Fill-once mode (R5)
    trace_en = 1'b0;
    step();
    wrap_mode = 1'b0;
    trace_en = 1'b1;
    step();
    for (int i = 0; i < DEPTH; i++) begin
      cap(pl(500 + i), 1'b1, "R5 single fill");
      chk(!thr_irq, "R9 disabled threshold", EW'(thr_irq), '0);
    end
    rd_entry(e, lat, hok);
    chk(e === {2'b01, pl(500)}, "R5 first entry", e, {2'b01, pl(500)});
    cap(pl(700), 1'b0, "R5 no capture after fill");
    for (int i = 1; i < DEPTH; i++) begin
      rd_entry(e, lat, hok);
      chk(e === {2'b01, pl(500 + i)}, "R5 drain", e, {2'b01, pl(500 + i)});
    end
    rd_entry(e, lat, hok);
    chk(e === '0, "R5 empty without gap", e, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule